// File: doc/BRIEF.md
# I2C Master Command and Status Front End

This block is the software-facing side of an I2C master. A processor writes a target address, a data byte, a clock period value and a command word through a small register port. The block turns each accepted command into a sequence of requests to a byte-level bus engine: win the bus, move one byte, release the bus. The engine handles the SCL/SDA bit timing. The block keeps its own record of whether it holds the bus and reports the outcome of each command in a status byte: error, arbitration lost, address and data not-acknowledged, busy, idle and bus-busy. A completion interrupt is raised whenever a byte finishes moving.

A small state machine runs each command. The states are ST_IDLE, ST_START, ST_XFER, ST_STOP and ST_FLUSH.
- ST_IDLE goes to ST_START on an accepted command with the start bit set while the bus is not held.
- Any other accepted command decides at once:
  - with the bus not held, it sets the error flag and returns to ST_IDLE;
  - with the bus held and the run bit set, it goes to ST_XFER;
  - with the bus held and only the stop bit set, it goes to ST_STOP;
  - otherwise it stays in ST_IDLE.
- ST_START, on the engine's start completion, applies the same decision using the start result.
- ST_XFER, on byte completion, goes to ST_STOP if the stop bit was given, else to ST_IDLE.
- ST_STOP returns to ST_IDLE on stop completion.
- A reset taken while the bus is held, or while a command is in flight, enters ST_FLUSH. ST_FLUSH holds a stop request to the engine until the engine completes it, then enters ST_IDLE.

Register map. The port is 3 address bits by 8 data bits. Reads have no side effects.

| Address | Register | Write | Read |
|---|---|---|---|
| 0 | Configuration | Keeps only mask 0x31; bit 4 is master enable | Stored value |
| 1 | Target | Bits [7:1] are the address, bit 0 the direction (1 = read) | Stored value |
| 2 | Data | Stored | Stored value |
| 3 | Command / status | Command: bit 0 run, bit 1 start, bit 2 stop | Status byte |
| 4 | Period | Stored | Stored value |
| 5 | Interrupt mask | Bit 0 | Stored value |
| 6 | Interrupt clear / raw | Writing bit 0 = 1 clears the raw interrupt | Raw interrupt |
| 7 | Masked interrupt | Ignored | Masked interrupt |

Status bits: busy 0x01, error 0x02, address-nack 0x04, data-nack 0x08, arbitration-lost 0x10, idle 0x20, bus-busy 0x40.

Top module: `i2cm_cmd_front`

## Requirements
- R1: After reset, every register reads 0, the status byte reads 0x20 (idle only), and `irq` is low.
- R2: A configuration write keeps only bits 0x31. The target, data and period registers keep all 8 bits written, and the period value appears on `eng_scl_period`.
- R3: A command write is ignored while configuration bit 4 is 0. No engine request follows, and the status byte is unchanged.
- R4: A command with bit 1 (start) set while the bus is not held raises `eng_start_req` with `eng_tgt_addr` equal to target bits [7:1].
  - If the start fails, arbitration-lost (0x10) and error (0x02) are set, and bus-busy (0x40) stays clear.
  - If it succeeds, arbitration-lost is cleared, bus-busy is set, and address-nack (0x04) takes `eng_nack`.
- R5: A command issued while the bus is not held after the start step sets error (0x02) and moves no byte. A command issued with the bus held clears error.
- R6: With the bus held, command bit 0 (run) moves one byte in the direction of target bit 0.
  - A write sends the data register on `eng_tx_byte`.
  - A read stores `eng_rx_byte` into the data register, taking priority over a software data write in the same cycle.
  - Data-nack (0x08) takes `eng_nack` at byte completion.
- R7: The raw interrupt (address 6, bit 0) is set when a byte completes. The masked interrupt (address 7) equals raw AND mask, and `irq` equals the masked bit.
- R8: Writing 1 to address 6 bit 0 clears the raw interrupt. A byte completion in the same cycle wins, and the raw interrupt stays 1.
- R9: Command bit 2 (stop) on a held bus raises `eng_stop_req` after any byte, and clears bus-busy on stop completion. A start command while the bus is already held issues no new start request.
- R10: Status bit 0x01 (busy) is 1 while a command is in progress. Idle (0x20) reads 1 only when neither busy nor bus-busy is set. A command written while busy is ignored. At most one engine request is active at a time.
- R11: A reset taken while the bus is held raises `eng_stop_req` until `eng_stop_done`, clears all registers, and afterwards the status byte reads 0x20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Completion interrupt |
| eng_scl_period | output | 8 | Period value for the bit-timing engine |
| eng_tgt_addr | output | 7 | 7-bit target address for the start step |
| eng_start_req | output | 1 | Request to win the bus and send the address |
| eng_start_done | input | 1 | Start step complete (one-cycle pulse) |
| eng_start_ok | input | 1 | Start succeeded (valid with `eng_start_done`) |
| eng_xfer_req | output | 1 | Request to move one byte |
| eng_xfer_rd | output | 1 | Byte direction, 1 = read |
| eng_tx_byte | output | 8 | Byte to send |
| eng_xfer_done | input | 1 | Byte complete (one-cycle pulse) |
| eng_rx_byte | input | 8 | Received byte (valid with `eng_xfer_done`) |
| eng_nack | input | 1 | Not-acknowledged result, valid with a start or byte completion |
| eng_stop_req | output | 1 | Request to release the bus |
| eng_stop_done | input | 1 | Stop complete (one-cycle pulse) |

## Verification
The raw-interrupt set from a completing byte and a software write of the clear bit can land in the same clock edge. The bench provokes this by watching the engine model's byte counter. It drives the clear write on exactly the cycle the engine raises `eng_xfer_done`, and then expects the raw interrupt to read 1.

A busy-time command collision is also provoked: a stop command is written while a slow transfer is in flight. The bench expects it to leave the bus held.

Random commands then mix enable states, start outcomes, nack results and directions, and are compared against a bench model of the status flags.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

    // register addresses
    localparam logic [2:0] A_CFG    = 3'd0;
    localparam logic [2:0] A_TGT    = 3'd1;
    localparam logic [2:0] A_DATA   = 3'd2;
    localparam logic [2:0] A_CMDST  = 3'd3;
    localparam logic [2:0] A_PERIOD = 3'd4;
    localparam logic [2:0] A_IMASK  = 3'd5;
    localparam logic [2:0] A_ICLR   = 3'd6;
    localparam logic [2:0] A_IMSTAT = 3'd7;

    // command bits
    localparam int C_RUN   = 0;
    localparam int C_START = 1;
    localparam int C_STOP  = 2;

    // status bit positions
    localparam int S_BUSY   = 0;
    localparam int S_ERR    = 1;
    localparam int S_ANACK  = 2;
    localparam int S_DNACK  = 3;
    localparam int S_ARB    = 4;
    localparam int S_IDLE   = 5;
    localparam int S_BUSBSY = 6;

    localparam int CFG_EN_BIT = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_XFER,
        ST_STOP,
        ST_FLUSH
    } cmd_state_t;

endpackage

// File: rtl/i2cm_regfile.sv
module i2cm_regfile
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rx_load,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              byte_done,
    output logic [DATA_W-1:0] cfg_q,
    output logic [DATA_W-1:0] tgt_q,
    output logic [DATA_W-1:0] data_q,
    output logic [DATA_W-1:0] period_q,
    output logic              mask_q,
    output logic              raw_q
);

    localparam logic [DATA_W-1:0] CFG_KEEP = DATA_W'(8'h31);

    logic clr_hit;
    assign clr_hit = wr && (addr == ADDR_W'(A_ICLR)) && wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q    <= '0;
            tgt_q    <= '0;
            data_q   <= '0;
            period_q <= '0;
            mask_q   <= 1'b0;
        end else begin
            if (wr) begin
                unique case (addr)
                    ADDR_W'(A_CFG):    cfg_q    <= wdata & CFG_KEEP;
                    ADDR_W'(A_TGT):    tgt_q    <= wdata;
                    ADDR_W'(A_PERIOD): period_q <= wdata;
                    ADDR_W'(A_IMASK):  mask_q   <= wdata[0];
                    default: ;
                endcase
            end
            // a received byte beats a software write in the same cycle
            if (rx_load) begin
                data_q <= rx_byte;
            end else if (wr && addr == ADDR_W'(A_DATA)) begin
                data_q <= wdata;
            end
        end
    end

    // completion sets, software clears; set wins a same-cycle collision
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw_q <= 1'b0;
        end else if (byte_done) begin
            raw_q <= 1'b1;
        end else if (clr_hit) begin
            raw_q <= 1'b0;
        end
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        byte_done |=> raw_q); // R8
    AST_RX_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        rx_load |=> (data_q == $past(rx_byte))); // R6

endmodule

// File: rtl/i2cm_cmd_fsm.sv
module i2cm_cmd_fsm
    import i2cm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       go,
    input  logic [2:0] cmd,
    input  logic       dir_rd,
    input  logic       eng_start_done,
    input  logic       eng_start_ok,
    input  logic       eng_xfer_done,
    input  logic       eng_nack,
    input  logic       eng_stop_done,
    output logic       start_req,
    output logic       xfer_req,
    output logic       stop_req,
    output logic       busy,
    output logic       owned,
    output logic       err_flag,
    output logic       arb_flag,
    output logic       anack_flag,
    output logic       dnack_flag,
    output logic       byte_done,
    output logic       rx_load
);

    cmd_state_t state, state_nx;
    logic       run_q, stop_q;
    logic       need_flush;

    // after bus ownership is settled: pick the next step of the command
    function automatic cmd_state_t after_own(input logic own, input logic run,
                                             input logic stp);
        if (!own)     return ST_IDLE;
        if (run)      return ST_XFER;
        if (stp)      return ST_STOP;
        return ST_IDLE;
    endfunction

    assign need_flush = owned
                     || (state == ST_START) || (state == ST_XFER)
                     || (state == ST_STOP)
                     || ((state == ST_FLUSH) && !eng_stop_done);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= need_flush ? ST_FLUSH : ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (go) begin
                    if (cmd[C_START] && !owned) state_nx = ST_START;
                    else state_nx = after_own(owned, cmd[C_RUN], cmd[C_STOP]);
                end
            end
            ST_START: if (eng_start_done) state_nx = after_own(eng_start_ok, run_q, stop_q);
            ST_XFER:  if (eng_xfer_done)  state_nx = stop_q ? ST_STOP : ST_IDLE;
            ST_STOP:  if (eng_stop_done)  state_nx = ST_IDLE;
            ST_FLUSH: if (eng_stop_done)  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start_req = 1'b0;
        xfer_req  = 1'b0;
        stop_req  = 1'b0;
        unique case (state)
            ST_START:          start_req = 1'b1;
            ST_XFER:           xfer_req  = 1'b1;
            ST_STOP, ST_FLUSH: stop_req  = 1'b1;
            default: ;
        endcase
    end

    assign busy      = (state != ST_IDLE);
    assign byte_done = (state == ST_XFER) && eng_xfer_done;
    assign rx_load   = byte_done && dir_rd;

    // ownership and result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q      <= 1'b0;
            stop_q     <= 1'b0;
            owned      <= 1'b0;
            err_flag   <= 1'b0;
            arb_flag   <= 1'b0;
            anack_flag <= 1'b0;
            dnack_flag <= 1'b0;
        end else begin
            if (go && state == ST_IDLE) begin
                run_q  <= cmd[C_RUN];
                stop_q <= cmd[C_STOP];
                if (!(cmd[C_START] && !owned)) err_flag <= !owned;
            end
            if (state == ST_START && eng_start_done) begin
                owned    <= eng_start_ok;
                arb_flag <= !eng_start_ok;
                err_flag <= !eng_start_ok;
                if (eng_start_ok) anack_flag <= eng_nack;
            end
            if (byte_done) dnack_flag <= eng_nack;
            if (state == ST_STOP && eng_stop_done) owned <= 1'b0;
        end
    end

    AST_START_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        start_req |-> !owned); // R4
    AST_XFER_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_req |-> owned); // R5
    AST_ONE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_req, xfer_req, stop_req})); // R10
    AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_req && eng_stop_done) |=> !owned); // R9

endmodule

// File: rtl/i2cm_cmd_front.sv
module i2cm_cmd_front
    import i2cm_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq,
    output logic [DATA_W-1:0] eng_scl_period,
    output logic [6:0]        eng_tgt_addr,
    output logic              eng_start_req,
    input  logic              eng_start_done,
    input  logic              eng_start_ok,
    output logic              eng_xfer_req,
    output logic              eng_xfer_rd,
    output logic [DATA_W-1:0] eng_tx_byte,
    input  logic              eng_xfer_done,
    input  logic [DATA_W-1:0] eng_rx_byte,
    input  logic              eng_nack,
    output logic              eng_stop_req,
    input  logic              eng_stop_done
);

    logic [DATA_W-1:0] cfg_q, tgt_q, data_q, period_q, status;
    logic              mask_q, raw_q, masked;
    logic              cmd_wr, go;
    logic              busy, owned, err_flag, arb_flag, anack_flag, dnack_flag;
    logic              byte_done, rx_load;

    assign cmd_wr = reg_wr && (reg_addr == ADDR_W'(A_CMDST));
    assign go     = cmd_wr && cfg_q[CFG_EN_BIT] && !busy;

    i2cm_regfile #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .rx_load   (rx_load),
        .rx_byte   (eng_rx_byte),
        .byte_done (byte_done),
        .cfg_q     (cfg_q),
        .tgt_q     (tgt_q),
        .data_q    (data_q),
        .period_q  (period_q),
        .mask_q    (mask_q),
        .raw_q     (raw_q)
    );

    i2cm_cmd_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .go             (go),
        .cmd            (reg_wdata[2:0]),
        .dir_rd         (tgt_q[0]),
        .eng_start_done (eng_start_done),
        .eng_start_ok   (eng_start_ok),
        .eng_xfer_done  (eng_xfer_done),
        .eng_nack       (eng_nack),
        .eng_stop_done  (eng_stop_done),
        .start_req      (eng_start_req),
        .xfer_req       (eng_xfer_req),
        .stop_req       (eng_stop_req),
        .busy           (busy),
        .owned          (owned),
        .err_flag       (err_flag),
        .arb_flag       (arb_flag),
        .anack_flag     (anack_flag),
        .dnack_flag     (dnack_flag),
        .byte_done      (byte_done),
        .rx_load        (rx_load)
    );

    assign masked         = raw_q & mask_q;
    assign irq            = masked;
    assign eng_scl_period = period_q;
    assign eng_tgt_addr   = tgt_q[7:1];
    assign eng_xfer_rd    = tgt_q[0];
    assign eng_tx_byte    = data_q;

    always_comb begin
        status           = '0;
        status[S_BUSY]   = busy;
        status[S_ERR]    = err_flag;
        status[S_ANACK]  = anack_flag;
        status[S_DNACK]  = dnack_flag;
        status[S_ARB]    = arb_flag;
        status[S_IDLE]   = !busy && !owned;
        status[S_BUSBSY] = owned;
    end

    always_comb begin
        unique case (reg_addr)
            ADDR_W'(A_CFG):    reg_rdata = cfg_q;
            ADDR_W'(A_TGT):    reg_rdata = tgt_q;
            ADDR_W'(A_DATA):   reg_rdata = data_q;
            ADDR_W'(A_CMDST):  reg_rdata = status;
            ADDR_W'(A_PERIOD): reg_rdata = period_q;
            ADDR_W'(A_IMASK):  reg_rdata = DATA_W'(mask_q);
            ADDR_W'(A_ICLR):   reg_rdata = DATA_W'(raw_q);
            default:           reg_rdata = DATA_W'(masked);
        endcase
    end

    AST_DISABLED_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !cfg_q[CFG_EN_BIT] && !busy) |=> !busy); // R3

endmodule

// File: tb/i2cm_cmd_front_bench.sv
module i2cm_cmd_front_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    wire  [7:0] reg_rdata;
    wire        irq;
    wire  [7:0] eng_scl_period;
    wire  [6:0] eng_tgt_addr;
    wire        eng_start_req, eng_xfer_req, eng_xfer_rd, eng_stop_req;
    wire  [7:0] eng_tx_byte;
    wire        eng_nack;

    // engine model controls
    int         s_dly = 1, x_dly = 1, p_dly = 1;
    int         s_cnt = 0, x_cnt = 0, p_cnt = 0;
    int         n_start = 0, n_xfer = 0, n_stop = 0;
    logic       sdone = 1'b0, xdone = 1'b0, pdone = 1'b0;
    logic       c_ok = 1'b1, c_na = 1'b0, c_nd = 1'b0;
    logic [7:0] c_rx = 8'h00;
    logic [7:0] cap_tx = 8'h00;
    logic [6:0] cap_addr = 7'h00;

    // bench model
    logic       m_en = 0, m_own = 0, m_err = 0, m_arb = 0, m_an = 0, m_dn = 0;
    logic       m_raw = 0, m_mask = 0;
    logic [7:0] m_data = 0, m_tgt = 0;
    int         n_chk = 0, n_err = 0;
    logic [7:0] v;

    assign eng_nack = sdone ? c_na : c_nd;

    always #2.5 clk = ~clk;

    i2cm_cmd_front u_i2cm_cmd_front (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .eng_scl_period(eng_scl_period), .eng_tgt_addr(eng_tgt_addr),
        .eng_start_req(eng_start_req), .eng_start_done(sdone), .eng_start_ok(c_ok),
        .eng_xfer_req(eng_xfer_req), .eng_xfer_rd(eng_xfer_rd), .eng_tx_byte(eng_tx_byte),
        .eng_xfer_done(xdone), .eng_rx_byte(c_rx), .eng_nack(eng_nack),
        .eng_stop_req(eng_stop_req), .eng_stop_done(pdone)
    );

    // byte-level engine model, driven away from the active edge
    always @(negedge clk) begin
        if (sdone) sdone <= 1'b0;
        else if (eng_start_req) begin
            if (s_cnt >= s_dly - 1) begin
                sdone <= 1'b1; s_cnt <= 0; n_start <= n_start + 1; cap_addr <= eng_tgt_addr;
            end else s_cnt <= s_cnt + 1;
        end else s_cnt <= 0;
        if (xdone) xdone <= 1'b0;
        else if (eng_xfer_req) begin
            if (x_cnt >= x_dly - 1) begin
                xdone <= 1'b1; x_cnt <= 0; n_xfer <= n_xfer + 1; cap_tx <= eng_tx_byte;
            end else x_cnt <= x_cnt + 1;
        end else x_cnt <= 0;
        if (pdone) pdone <= 1'b0;
        else if (eng_stop_req) begin
            if (p_cnt >= p_dly - 1) begin
                pdone <= 1'b1; p_cnt <= 0; n_stop <= n_stop + 1;
            end else p_cnt <= p_cnt + 1;
        end else p_cnt <= 0;
    end

    function automatic logic [7:0] f_status();
        return {1'b0, m_own, !m_own, m_arb, m_dn, m_an, m_err, 1'b0};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] val);
        @(negedge clk);
        reg_addr = a;
        #1 val = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int k = 0; k < 300; k++) begin
            rd(3'd3, s);
            if (!s[0]) break;
        end
    endtask

    task automatic set_cfg(input logic [7:0] d);
        wr(3'd0, d);
        m_en = d[4];
    endtask

    // expected effect of an accepted command
    task automatic model_apply(input logic [2:0] cmd, input int ns0, input int nx0, input int np0);
        logic need_start;
        need_start = m_en && cmd[1] && !m_own;
        if (!m_en) begin
            chk("R3 no start", 8'(n_start - ns0), 8'd0);
            chk("R3 no byte", 8'(n_xfer - nx0), 8'd0);
            return;
        end
        if (need_start) begin
            chk("R4 start issued", 8'(n_start - ns0), 8'd1);
            chk("R4 target address", {1'b0, cap_addr}, {1'b0, m_tgt[7:1]});
            m_own = c_ok; m_arb = !c_ok;
            if (c_ok) m_an = c_na;
        end else begin
            chk("R9 no new start", 8'(n_start - ns0), 8'd0);
        end
        if (!m_own) begin
            m_err = 1'b1;
            chk("R5 no byte without bus", 8'(n_xfer - nx0), 8'd0);
            return;
        end
        m_err = 1'b0;
        if (cmd[0]) begin
            chk("R6 one byte", 8'(n_xfer - nx0), 8'd1);
            if (!m_tgt[0]) chk("R6 tx byte", cap_tx, m_data);
            else m_data = c_rx;
            m_dn = c_nd;
            m_raw = 1'b1;
        end
        if (cmd[2]) begin
            chk("R9 stop issued", 8'(n_stop - np0), 8'd1);
            m_own = 1'b0;
        end
    endtask

    task automatic check_all(input string tag);
        logic [7:0] r;
        rd(3'd3, r); chk({tag, " status"}, r, f_status());
        rd(3'd2, r); chk({tag, " data"}, r, m_data);
        rd(3'd6, r); chk({"R7 raw ", tag}, r, {7'd0, m_raw});
        rd(3'd7, r); chk({"R7 masked ", tag}, r, {7'd0, m_raw & m_mask});
        chk({"R7 irq ", tag}, {7'd0, irq}, {7'd0, m_raw & m_mask});
    endtask

    task automatic do_cmd(input logic [2:0] cmd, input string tag);
        int ns0, nx0, np0;
        ns0 = n_start; nx0 = n_xfer; np0 = n_stop;
        wr(3'd3, {5'd0, cmd});
        wait_idle();
        model_apply(cmd, ns0, nx0, np0);
        check_all(tag);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R10 watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1c2a));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd3, v); chk("R1 status", v, 8'h20);
        rd(3'd0, v); chk("R1 cfg", v, 8'h00);
        rd(3'd2, v); chk("R1 data", v, 8'h00);
        rd(3'd6, v); chk("R1 raw", v, 8'h00);
        chk("R1 irq", {7'd0, irq}, 8'h00);

        // R2 register widths and masks
        wr(3'd0, 8'hFF); rd(3'd0, v); chk("R2 cfg mask", v, 8'h31);
        wr(3'd4, 8'hA7); rd(3'd4, v); chk("R2 period", v, 8'hA7);
        chk("R2 period out", eng_scl_period, 8'hA7);
        wr(3'd1, 8'h3C); rd(3'd1, v); chk("R2 target", v, 8'h3C);

        // R3 disabled command
        set_cfg(8'h00);
        m_tgt = 8'hA4; wr(3'd1, m_tgt);
        m_data = 8'h5A; wr(3'd2, m_data);
        do_cmd(3'b011, "R3");

        // R5 run without bus
        set_cfg(8'h10);
        do_cmd(3'b001, "R5");

        // R4 failed start
        c_ok = 1'b0;
        do_cmd(3'b011, "R4 fail");

        // R4/R6 successful start, write byte, address nack
        c_ok = 1'b1; c_na = 1'b1; c_nd = 1'b0;
        do_cmd(3'b011, "R4 ok");
        m_mask = 1'b1; wr(3'd5, 8'h01);
        check_all("R7 mask on");

        // R8 clear
        wr(3'd6, 8'h01); m_raw = 1'b0;
        check_all("R8 clear");

        // R9/R6 start while held, read byte with data nack
        m_tgt = 8'hA5; wr(3'd1, m_tgt);
        c_rx = 8'hC3; c_nd = 1'b1;
        do_cmd(3'b011, "R6 read");

        // R6 rx load beats software data write in the same cycle
        x_dly = 3;
        begin
            int ns0, nx0, np0;
            ns0 = n_start; nx0 = n_xfer; np0 = n_stop;
            c_rx = 8'h96;
            wr(3'd3, 8'h01);
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (eng_xfer_req && !xdone && x_cnt == x_dly - 1) begin
                    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 8'h11;
                    @(negedge clk); reg_wr = 1'b0;
                    break;
                end
            end
            wait_idle();
            model_apply(3'b001, ns0, nx0, np0);
            check_all("R6 rx priority");
        end

        // R8 clear collides with completion: set wins
        wr(3'd6, 8'h01); m_raw = 1'b0;
        begin
            int ns0, nx0, np0;
            ns0 = n_start; nx0 = n_xfer; np0 = n_stop;
            c_rx = 8'h4E;
            wr(3'd3, 8'h01);
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (eng_xfer_req && !xdone && x_cnt == x_dly - 1) begin
                    reg_wr = 1'b1; reg_addr = 3'd6; reg_wdata = 8'h01;
                    @(negedge clk); reg_wr = 1'b0;
                    break;
                end
            end
            wait_idle();
            model_apply(3'b001, ns0, nx0, np0);
            check_all("R8 set wins");
        end

        // R9 stop
        p_dly = 2;
        do_cmd(3'b100, "R9 stop");

        // R10 busy; command during busy ignored
        x_dly = 10;
        begin
            int ns0, nx0, np0;
            ns0 = n_start; nx0 = n_xfer; np0 = n_stop;
            m_tgt = 8'h40; wr(3'd1, m_tgt);
            c_ok = 1'b1; c_na = 1'b0; c_nd = 1'b0;
            wr(3'd3, 8'h03);
            rd(3'd3, v);
            chk("R10 busy bit", {6'd0, v[5], v[0]}, 8'h01);
            wr(3'd3, 8'h04);
            wait_idle();
            model_apply(3'b011, ns0, nx0, np0);
            chk("R10 ignored stop", 8'(n_stop - np0), 8'd0);
            check_all("R10");
        end

        // constrained random commands
        x_dly = 1;
        for (int i = 0; i < 80; i++) begin
            logic [7:0] cf;
            cf = 8'($urandom);
            cf[4] = (($urandom % 8) != 0);
            set_cfg(cf);
            m_tgt = 8'($urandom); wr(3'd1, m_tgt);
            m_data = 8'($urandom); wr(3'd2, m_data);
            m_mask = 1'($urandom); wr(3'd5, {7'd0, m_mask});
            c_ok = (($urandom % 4) != 0);
            c_na = 1'($urandom); c_nd = 1'($urandom);
            c_rx = 8'($urandom);
            s_dly = 1 + int'($urandom % 3);
            x_dly = 1 + int'($urandom % 3);
            p_dly = 1 + int'($urandom % 3);
            do_cmd(3'($urandom), "R10 random");
            if (m_raw && (($urandom % 2) != 0)) begin
                wr(3'd6, 8'h01); m_raw = 1'b0;
                rd(3'd6, v); chk("R8 random clear", v, 8'h00);
            end
        end

        // R11 reset while holding the bus
        set_cfg(8'h10);
        c_ok = 1'b1;
        if (!m_own) do_cmd(3'b010, "R11 prep");
        begin
            int np0;
            np0 = n_stop;
            p_dly = 2;
            @(negedge clk); rst_n = 1'b0;
            @(negedge clk);
            chk("R11 stop req in reset", {7'd0, eng_stop_req}, 8'h01);
            repeat (6) @(negedge clk);
            rst_n = 1'b1;
            chk("R11 stop done", 8'(n_stop - np0), 8'd1);
            m_own = 0; m_err = 0; m_arb = 0; m_an = 0; m_dn = 0; m_raw = 0;
            m_mask = 0; m_data = 0; m_en = 0;
            check_all("R11");
            rd(3'd0, v); chk("R11 cfg cleared", v, 8'h00);
        end

        finish_run();
    end

endmodule